// File: doc/BRIEF.md
# Scan-Chain Signature Verifier

This block proves ownership of a design whose scan chain has been reordered to hide a signature. In test mode it drives a fixed verification vector serially into an N-flop scan chain, lets the chain take one functional capture, and then unloads the whole response into a local register indexed by chain position. It then walks a programmable table of m positions in table order and compares each addressed response bit with the matching bit of an m-bit expected signature. Every other response bit is ignored.

The position table, signature bits and signature length are written through a small write port while the block is idle. A `start` pulse launches one run. At the end of the run `done` pulses for one cycle. `pass` or `fail` is then held until the next accepted start. A match on every entry proves the mark is present. Any mismatch means the chain is unmarked or the mark has been damaged. The chance that an unmarked chain matches by accident is 1/2^m.

Top module: `scan_wm_verifier`

## Requirements
- R1: During and directly after reset, `done`, `pass`, `fail`, `scanEnable` and `captureEn` are low.
- R2: A run starts with CHAIN_LEN shift cycles with `scanEnable` high. On the k-th shift cycle, `scanIn` carries bit k-1 of VERIFY_VEC. The chain shifts from its `scanIn` end toward position 1, so the first bit driven settles at position 1, and after loading, position p holds VERIFY_VEC bit p-1.
- R3: Exactly one cycle with `captureEn` high and `scanEnable` low follows the load. The unload starts in the next cycle.
- R4: The unload is CHAIN_LEN shift cycles with `scanIn` held at 0. Position 1 (`scanOut`) is the first response bit taken, so the chain holds all zeros afterwards.
- R5: Table entry i (0-based) holds a position p, and it matches when response bit p equals signature bit i. Entries are taken in table order, not sorted by position. The run passes when entries 0 to m-1 all match, and it fails at the first mismatch without examining later entries.
- R6: Response bits at positions that are not in the table have no effect on the result.
- R7: A table entry of 0 or greater than CHAIN_LEN fails the run when that entry is reached.
- R8: A signature length of 0, greater than MAX_SIG, or not less than CHAIN_LEN fails the run at the first comparison.
- R9: A run that stops at comparison k (1-based) raises `done` for exactly one cycle, 2*CHAIN_LEN+1+k clock edges after the edge that samples `start`. Exactly one of `pass` and `fail` is set together with `done`. Both are cleared on the edge that accepts the next start and otherwise hold.
- R10: A `start` that arrives while a run is in progress is ignored. It changes neither the timing nor the result, and it produces no extra `done`.
- R11: A write with `cfgWe` high is taken only while idle. `cfgSel` 0 writes position entry `cfgIdx`. `cfgSel` 1 writes signature bit `cfgIdx` from `cfgData[0]`. `cfgSel` 2 writes the signature length. `cfgSel` 3 and all writes made during a run are ignored.
- R12: Any signature length from 1 to MAX_SIG is accepted, including MAX_SIG itself. The default MAX_SIG is 128, which covers 32, 64 and 128-bit signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one verification run when idle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Target: 0 position, 1 signature bit, 2 length |
| cfgIdx | input | IDX_W | Table / signature index |
| cfgData | input | DATA_W | Write data |
| scanOut | input | 1 | Serial output of the scan chain (position 1) |
| scanEnable | output | 1 | Shift enable toward the chain |
| scanIn | output | 1 | Serial data into the chain |
| captureEn | output | 1 | Capture-clock enable for the chain |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Signature found |
| fail | output | 1 | Signature absent or damaged |

## Verification
The delay from start to verdict is fixed. For a run that stops at comparison k, `done` is due 2N+1+k edges after the start edge. The bench counts edges from the start edge and compares that count with the figure computed from the expected stopping entry of each table row. Bench-side chain-model events are sampled on falling edges only, after every register has settled. These are the single capture, the vector present at capture and the all-zero chain after unload. The bench samples the held verdict, the clearing of the verdict after a new start and the absence of any second `done` at the same points.

// File: rtl/scan_wm_pkg.sv
package scan_wm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPT,
    ST_UNLOAD,
    ST_CMP
  } wm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;
    logic cntClr;
    logic cntInc;
    logic loadPhase;
    logic unloadPhase;
    logic cmpPhase;
  } wm_strobe_t;

  localparam logic [1:0] SEL_POS = 2'd0;
  localparam logic [1:0] SEL_SIG = 2'd1;
  localparam logic [1:0] SEL_LEN = 2'd2;

endpackage

// File: rtl/scan_wm_ctrl.sv
module scan_wm_ctrl
  import scan_wm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cntLast,
  input  logic       cmpLast,
  input  logic       cmpBad,
  output wm_strobe_t st,
  output logic       scanEnable,
  output logic       captureEn,
  output logic       done,
  output logic       pass,
  output logic       fail
);

  wm_state_e state, nextState;
  logic      finishing;

  always_comb begin
    nextState = state;
    st        = '0;
    st.busy   = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        st.cntClr = 1'b1;
        if (start) nextState = ST_LOAD;
      end
      ST_LOAD: begin
        st.loadPhase = 1'b1;
        st.cntInc    = 1'b1;
        if (cntLast) nextState = ST_CAPT;
      end
      ST_CAPT: begin
        st.cntClr = 1'b1;
        nextState = ST_UNLOAD;
      end
      ST_UNLOAD: begin
        st.unloadPhase = 1'b1;
        st.cntInc      = 1'b1;
        if (cntLast) nextState = ST_CMP;
      end
      ST_CMP: begin
        st.cmpPhase = 1'b1;
        if (cmpBad || cmpLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign finishing  = (state == ST_CMP) && (cmpBad || cmpLast);
  assign scanEnable = (state == ST_LOAD) || (state == ST_UNLOAD);
  assign captureEn  = (state == ST_CAPT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finishing;
      if ((state == ST_IDLE) && start) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else if (finishing) begin
        pass <= !cmpBad;
        fail <= cmpBad;
      end
    end
  end

  // R3
  capt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> (scanEnable && !captureEn));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail));

  // R9
  done_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass != fail));

endmodule

// File: rtl/scan_wm_dpath.sv
module scan_wm_dpath
  import scan_wm_pkg::*;
#(
  parameter int CHAIN_LEN = 256,
  parameter int MAX_SIG   = 128,
  parameter logic [CHAIN_LEN-1:0] VERIFY_VEC = CHAIN_LEN'({8{32'h5A3C_96E1}}),
  localparam int POS_W    = $clog2(CHAIN_LEN + 1),
  localparam int CNT_W    = $clog2(CHAIN_LEN),
  localparam int IDX_W    = $clog2(MAX_SIG),
  localparam int SIGCNT_W = $clog2(MAX_SIG + 1),
  localparam int DATA_W   = (POS_W > SIGCNT_W) ? POS_W : SIGCNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wm_strobe_t        st,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              scanOut,
  output logic              scanIn,
  output logic              cntLast,
  output logic              cmpLast,
  output logic              cmpBad
);

  logic [POS_W-1:0]     posTab [MAX_SIG];
  logic [MAX_SIG-1:0]   sigBits;
  logic [DATA_W-1:0]    sigLen;
  logic [CHAIN_LEN-1:0] resp;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;

  logic [POS_W-1:0] curPos;
  logic [CNT_W-1:0] respSel;
  logic             posOk, lenOk, bitHit;

  // configuration store, writable only while idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigBits <= '0;
      sigLen  <= '0;
    end else if (cfgWe && !st.busy) begin
      if (cfgSel == SEL_SIG) sigBits[cfgIdx] <= cfgData[0];
      if (cfgSel == SEL_LEN) sigLen <= cfgData;
    end
  end

  for (genvar g = 0; g < MAX_SIG; g++) begin : g_pos
    always_ff @(posedge clk) begin
      if (!rstN)
        posTab[g] <= '0;
      else if (cfgWe && !st.busy && (cfgSel == SEL_POS) && (cfgIdx == IDX_W'(g)))
        posTab[g] <= POS_W'(cfgData);
    end
  end

  // shift counter shared by load and unload
  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (st.cntClr) cnt <= '0;
    else if (st.cntInc) cnt <= cnt + 1'b1;
  end

  assign cntLast = (cnt == CNT_W'(CHAIN_LEN - 1));
  assign scanIn  = st.loadPhase ? VERIFY_VEC[cnt] : 1'b0;

  // response register, bit p-1 holds position p
  always_ff @(posedge clk) begin
    if (!rstN)               resp <= '0;
    else if (st.unloadPhase) resp[cnt] <= scanOut;
  end

  // table walk
  always_ff @(posedge clk) begin
    if (!rstN)            idx <= '0;
    else if (st.cmpPhase) idx <= idx + 1'b1;
    else                  idx <= '0;
  end

  assign curPos  = posTab[idx];
  assign respSel = CNT_W'(curPos - POS_W'(1));
  assign posOk   = (curPos != '0) && (curPos <= POS_W'(CHAIN_LEN));
  assign lenOk   = (sigLen != '0) && (sigLen <= DATA_W'(MAX_SIG)) &&
                   (sigLen < DATA_W'(CHAIN_LEN));
  assign bitHit  = (resp[respSel] == sigBits[idx]);
  assign cmpBad  = !lenOk || !posOk || !bitHit;
  assign cmpLast = ((DATA_W'(idx) + DATA_W'(1)) == sigLen);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.busy |=> $stable(sigLen));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmpPhase && !cmpBad) |-> (DATA_W'(idx) < sigLen));

endmodule

// File: rtl/scan_wm_verifier.sv
module scan_wm_verifier
  import scan_wm_pkg::*;
#(
  parameter int CHAIN_LEN = 256,
  parameter int MAX_SIG   = 128,
  parameter logic [CHAIN_LEN-1:0] VERIFY_VEC = CHAIN_LEN'({8{32'h5A3C_96E1}}),
  localparam int POS_W    = $clog2(CHAIN_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_SIG),
  localparam int SIGCNT_W = $clog2(MAX_SIG + 1),
  localparam int DATA_W   = (POS_W > SIGCNT_W) ? POS_W : SIGCNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              scanOut,
  output logic              scanEnable,
  output logic              scanIn,
  output logic              captureEn,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  wm_strobe_t st;
  logic cntLast, cmpLast, cmpBad;

  scan_wm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cntLast    (cntLast),
    .cmpLast    (cmpLast),
    .cmpBad     (cmpBad),
    .st         (st),
    .scanEnable (scanEnable),
    .captureEn  (captureEn),
    .done       (done),
    .pass       (pass),
    .fail       (fail)
  );

  scan_wm_dpath #(
    .CHAIN_LEN  (CHAIN_LEN),
    .MAX_SIG    (MAX_SIG),
    .VERIFY_VEC (VERIFY_VEC)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .scanOut (scanOut),
    .scanIn  (scanIn),
    .cntLast (cntLast),
    .cmpLast (cmpLast),
    .cmpBad  (cmpBad)
  );

endmodule

// File: tb/scan_wm_verifier_tb_top.sv
`timescale 1ns/1ps
module scan_wm_verifier_tb_top;

  localparam int N      = 8;
  localparam int MS     = 4;
  localparam logic [N-1:0] VEC = 8'b11011000; // positions 1..8 = 0,0,0,1,1,0,1,1
  localparam int IDX_W  = 2;
  localparam int DATA_W = 4;

  typedef struct packed {
    logic [7:0]  mask;    // capture flips these response bits
    logic [3:0]  len;
    logic [15:0] pos;     // entry i at [4i+3:4i]
    logic [3:0]  sig;     // bit i = signature bit for entry i
    logic        expPass;
    logic [3:0]  expK;    // comparison index where the run stops
    logic [3:0]  req;
  } row_t;

  localparam row_t ROWS [10] = '{
    '{8'b11001111, 4'd3, 16'h0725, 4'b0011, 1'b1, 4'd3, 4'd5},
    '{8'b11001111, 4'd3, 16'h0725, 4'b0001, 1'b0, 4'd2, 4'd5},
    '{8'b11001111, 4'd3, 16'h0257, 4'b0011, 1'b0, 4'd1, 4'd5},
    '{8'b00000000, 4'd4, 16'h6418, 4'b0101, 1'b1, 4'd4, 4'd12},
    '{8'b00000000, 4'd2, 16'h0008, 4'b0001, 1'b0, 4'd2, 4'd7},
    '{8'b00000000, 4'd1, 16'h0009, 4'b0001, 1'b0, 4'd1, 4'd7},
    '{8'b00000000, 4'd0, 16'h0725, 4'b0011, 1'b0, 4'd1, 4'd8},
    '{8'b00000000, 4'd5, 16'h6418, 4'b0101, 1'b0, 4'd1, 4'd8},
    '{8'b00000000, 4'd4, 16'h6418, 4'b1101, 1'b0, 4'd4, 4'd5},
    '{8'b01100010, 4'd3, 16'h0725, 4'b0011, 1'b1, 4'd3, 4'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [DATA_W-1:0] cfgData = '0;
  logic scanOut, scanEnable, scanIn, captureEn, done, pass, fail;

  logic [N-1:0] ch = '0;
  logic [N-1:0] xmask = '0;
  logic [N-1:0] loadedSnap = '0;
  logic [7:0]   capCount = '0;
  logic [7:0]   doneCount = '0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scan_wm_verifier #(.CHAIN_LEN(N), .MAX_SIG(MS), .VERIFY_VEC(VEC)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .scanOut(scanOut),
    .scanEnable(scanEnable), .scanIn(scanIn), .captureEn(captureEn),
    .done(done), .pass(pass), .fail(fail)
  );

  // behavioural scan chain: bit p-1 is position p, scanOut at position 1
  assign scanOut = ch[0];
  always @(posedge clk) begin
    if (scanEnable) ch <= {scanIn, ch[N-1:1]};
    else if (captureEn) begin
      ch         <= ch ^ xmask;
      loadedSnap <= ch;
    end
    if (captureEn) capCount <= capCount + 8'd1;
    if (done) doneCount <= doneCount + 8'd1;
  end

  function automatic string tagOf(input int n);
    case (n)
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input int idx, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = IDX_W'(idx); cfgData = DATA_W'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadRow(input row_t r);
    cfgWrite(2'd2, 0, int'(r.len));
    for (int i = 0; i < MS; i++) cfgWrite(2'd0, i, int'(r.pos[4*i +: 4]));
    for (int i = 0; i < MS; i++) cfgWrite(2'd1, i, int'(r.sig[i]));
    xmask = r.mask;
  endtask

  // poke 1: start pulse mid-run, poke 2: sig bit 1 write mid-run
  task automatic runScan(input int pokeAt, input int pokeKind,
                         output int lat, output bit clearedOk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clearedOk = !pass && !fail;
    lat = 0;
    while (!done && lat < 200) begin
      if (lat == pokeAt) begin
        if (pokeKind == 1) start = 1'b1;
        if (pokeKind == 2) begin
          cfgWe = 1'b1; cfgSel = 2'd1; cfgIdx = 2'd1; cfgData = '0;
        end
      end
      @(negedge clk);
      start = 1'b0;
      cfgWe = 1'b0;
      lat++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int lat;
    bit clr;
    logic [7:0] cap0, done0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!done && !pass && !fail && !scanEnable && !captureEn, "R1",
          {done, pass, fail, scanEnable, captureEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !pass && !fail && !scanEnable && !captureEn, "R1",
          {done, pass, fail, scanEnable, captureEn}, 0);

    // table walk
    for (int r = 0; r < 10; r++) begin
      loadRow(ROWS[r]);
      cap0 = capCount;
      runScan(-1, 0, lat, clr);
      check(pass == ROWS[r].expPass && fail == !ROWS[r].expPass, tagOf(int'(ROWS[r].req)),
            {pass, fail}, {ROWS[r].expPass, !ROWS[r].expPass});
      check(lat == 2*N + 1 + int'(ROWS[r].expK), "R9", lat, 2*N + 1 + int'(ROWS[r].expK));
      check(clr, "R9", int'(clr), 1);
      check(capCount - cap0 == 8'd1, "R3", int'(capCount - cap0), 1);
      check(loadedSnap == VEC, "R2", int'(loadedSnap), int'(VEC));
      check(ch == '0, "R4", int'(ch), 0);
    end

    // R9: verdict held, single done pulse
    loadRow(ROWS[0]);
    done0 = doneCount;
    runScan(-1, 0, lat, clr);
    repeat (10) @(negedge clk);
    check(pass && !fail && !done, "R9", {pass, fail, done}, 3'b100);
    check(doneCount - done0 == 8'd1, "R9", int'(doneCount - done0), 1);

    // R10: start during a run
    done0 = doneCount;
    runScan(6, 1, lat, clr);
    repeat (30) @(negedge clk);
    check(lat == 2*N + 4, "R10", lat, 2*N + 4);
    check(doneCount - done0 == 8'd1 && pass, "R10", int'(doneCount - done0), 1);

    // R11: signature write during a run is dropped
    runScan(5, 2, lat, clr);
    check(pass && !fail, "R11", {pass, fail}, 2'b10);
    runScan(-1, 0, lat, clr);
    check(pass && !fail, "R11", {pass, fail}, 2'b10);

    // R11: select code 3 ignored
    cfgWrite(2'd3, 1, 0);
    runScan(-1, 0, lat, clr);
    check(pass && !fail && lat == 2*N + 4, "R11", {pass, fail}, 2'b10);

    // R11: idle write does take effect (sig bit 1 -> 0, fails at entry 2)
    cfgWrite(2'd1, 1, 0);
    runScan(-1, 0, lat, clr);
    check(fail && !pass && lat == 2*N + 3, "R11", lat, 2*N + 3);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule